// File: doc/BRIEF.md
# Comparator Edge Interrupt Controller

This block is the digital shell around an analog comparator that is paired with a programmable reference generator. A small register bus sets it up. The block drives the comparator's positive-input and negative-input selects and the reference generator's level code and supply choice. It also drives the enables for the comparator, the reference generator, the output pad and each external input pad. The analog parts are not in the block. They appear only as plain digital ports.

The raw comparator output arrives with no timing relation to the bus clock. A synchronizer brings it into the bus clock domain, and the result is exposed as a read-only status bit. An edge detector watches the synchronized signal. A programmable mode decides which transitions count: both, falling only, rising only, or none (the reserved code). A qualifying transition sets a sticky flag, and the interrupt line is the flag gated by an interrupt enable. Input selects are frozen while the comparator runs, and the level code is frozen while the reference generator runs, so analog settling is never disturbed mid-operation.

Top module: `cmpirq_ctrl`

## Requirements
- R1: After reset all four registers read 0, every drive output is 0, and irq and cmp_status are 0.
- R2: cmp_status (also CTRL bit 6) follows cmp_raw with a latency of two bus-clock edges while the comparator is enabled, and it reads 0 while the comparator is disabled (CTRL bit 0 = 0).
- R3: With edge mode 00 (CTRL bits 4:3), both rising and falling transitions of the synchronized output set the flag (CTRL bit 5), on the third clock edge after cmp_raw changes.
- R4: With edge mode 01, only falling transitions set the flag.
- R5: With edge mode 10, only rising transitions set the flag.
- R6: With edge mode 11 (reserved), no transition sets the flag.
- R7: The flag is sticky. Writing CTRL with bit 5 = 1 clears it, and writing CTRL with bit 5 = 0 leaves it unchanged.
- R8: When a clear write and a qualifying transition occur in the same cycle, the flag ends set.
- R9: irq is high exactly when the flag is set and the interrupt enable (CTRL bit 1) is set.
- R10: INSEL (address 1, positive select in bits 2:0, negative select in bits 5:3) is written only while the comparator is disabled. Writes to it while the comparator is enabled are ignored.
- R11: The level code (REF address 2, bits 4:0) is written only while the reference enable (REF bit 6) is 0. The supply select (REF bit 5) and the enable itself are always writable.
- R12: Enabling the comparator while cmp_raw is already high sets no flag, and no transition is reported during the first three cycles after enable.
- R13: The pad-output enable (CTRL bit 2) and the external pad enables (PADEN address 3, bits 6:0) drive their ports directly and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| cmp_raw | input | 1 | Asynchronous analog comparator output |
| cmp_en | output | 1 | Comparator enable |
| ref_en | output | 1 | Reference generator enable |
| ref_src | output | 1 | Reference supply select |
| ref_level | output | 5 | Reference level code, 32 steps |
| pos_sel | output | 3 | Positive input select |
| neg_sel | output | 3 | Negative input select |
| pad_out_en | output | 1 | Comparator-to-pin enable |
| ext_pad_en | output | 7 | Per-input external pad enables |
| cmp_status | output | 1 | Synchronized comparator output |
| irq | output | 1 | Interrupt request |

## Verification
The case that is hardest to reach is R8, a flag clear that lands in the very clock edge where a new transition qualifies. The bench first sets the flag. It then toggles cmp_raw on a falling clock edge, lets exactly two rising edges pass, and places the clear write so that the third edge samples both events together. The warm-up window of R12 is covered by holding cmp_raw high before enabling and then confirming that the status rises while the flag stays clear.

// File: rtl/cmpirq_pkg.sv
package cmpirq_pkg;

   typedef enum logic [1:0] {
      EDGE_BOTH = 2'b00,
      EDGE_FALL = 2'b01,
      EDGE_RISE = 2'b10,
      EDGE_RSVD = 2'b11
   } edge_mode_e;

   localparam logic [1:0] ADDR_CTRL  = 2'd0;
   localparam logic [1:0] ADDR_INSEL = 2'd1;
   localparam logic [1:0] ADDR_REF   = 2'd2;
   localparam logic [1:0] ADDR_PADEN = 2'd3;

   localparam int CTRL_EN     = 0;
   localparam int CTRL_IRQEN  = 1;
   localparam int CTRL_PADOUT = 2;
   localparam int CTRL_MODE   = 3;
   localparam int CTRL_FLAG   = 5;
   localparam int CTRL_STAT   = 6;

endpackage

// File: rtl/cmpirq_sync.sv
module cmpirq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic async_in,
   output logic sync_out
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)   chain[0] <= 1'b0;
               else if (clr) chain[0] <= 1'b0;
               else          chain[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)   chain[i] <= 1'b0;
               else if (clr) chain[i] <= 1'b0;
               else          chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign sync_out = chain[STAGES-1];

   // R12: a held-off synchronizer presents a low output
   a_r12_sync_held: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !sync_out);

endmodule

// File: rtl/cmpirq_edge.sv
module cmpirq_edge #(
   parameter int STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   enable,
   input  logic                   sync_in,
   input  cmpirq_pkg::edge_mode_e mode,
   output logic                   qual
);
   import cmpirq_pkg::*;

   localparam int CNT_W = $clog2(STAGES + 2);
   localparam logic [CNT_W-1:0] ARM_AT = CNT_W'(STAGES + 1);

   logic             prev;
   logic [CNT_W-1:0] warm_cnt;
   logic             armed;
   logic             rose;
   logic             fell;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev     <= 1'b0;
         warm_cnt <= '0;
      end else if (!enable) begin
         prev     <= 1'b0;
         warm_cnt <= '0;
      end else begin
         prev <= sync_in;
         if (warm_cnt != ARM_AT) warm_cnt <= warm_cnt + 1'b1;
      end
   end

   assign armed = (warm_cnt == ARM_AT);
   assign rose  = sync_in & ~prev;
   assign fell  = ~sync_in & prev;

   always_comb begin
      qual = 1'b0;
      if (armed) begin
         unique case (mode)
            EDGE_BOTH: qual = rose | fell;
            EDGE_FALL: qual = fell;
            EDGE_RISE: qual = rose;
            EDGE_RSVD: qual = 1'b0;
            default:   qual = 1'b0;
         endcase
      end
   end

   // R6: reserved mode stays silent
   a_r6_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == EDGE_RSVD) |-> !qual);
   // R5: rising-only mode reports only when the input is now high
   a_r5_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == EDGE_RISE && qual) |-> sync_in);
   // R4: falling-only mode reports only when the input is now low
   a_r4_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == EDGE_FALL && qual) |-> !sync_in);
   // R12: nothing qualifies while disabled or in the cycle right after enabling
   a_r12_no_edge_off: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !qual);

endmodule

// File: rtl/cmpirq_regs.sv
module cmpirq_regs #(
   parameter int DATA_W  = 8,
   parameter int LEVEL_W = 5,
   parameter int SEL_W   = 3,
   parameter int N_EXT   = 7
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_wr,
   input  logic [1:0]             bus_addr,
   input  logic [DATA_W-1:0]      bus_wdata,
   output logic [DATA_W-1:0]      bus_rdata,
   input  logic                   edge_qual,
   input  logic                   status,
   output logic                   cmp_en,
   output logic                   irq_en,
   output logic                   pad_out_en,
   output cmpirq_pkg::edge_mode_e mode,
   output logic                   flag,
   output logic [SEL_W-1:0]       pos_sel,
   output logic [SEL_W-1:0]       neg_sel,
   output logic [LEVEL_W-1:0]     ref_level,
   output logic                   ref_src,
   output logic                   ref_en,
   output logic [N_EXT-1:0]       ext_pad_en
);
   import cmpirq_pkg::*;

   localparam int REF_SRC_BIT = LEVEL_W;
   localparam int REF_EN_BIT  = LEVEL_W + 1;
   localparam int NEG_LO      = SEL_W;

   logic wr_ctrl, wr_insel, wr_ref, wr_paden;
   logic flag_clr;

   assign wr_ctrl  = bus_wr && (bus_addr == ADDR_CTRL);
   assign wr_insel = bus_wr && (bus_addr == ADDR_INSEL);
   assign wr_ref   = bus_wr && (bus_addr == ADDR_REF);
   assign wr_paden = bus_wr && (bus_addr == ADDR_PADEN);
   assign flag_clr = wr_ctrl && bus_wdata[CTRL_FLAG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_en     <= 1'b0;
         irq_en     <= 1'b0;
         pad_out_en <= 1'b0;
         mode       <= EDGE_BOTH;
      end else if (wr_ctrl) begin
         cmp_en     <= bus_wdata[CTRL_EN];
         irq_en     <= bus_wdata[CTRL_IRQEN];
         pad_out_en <= bus_wdata[CTRL_PADOUT];
         mode       <= edge_mode_e'(bus_wdata[CTRL_MODE +: 2]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flag <= 1'b0;
      else if (edge_qual) flag <= 1'b1;
      else if (flag_clr)  flag <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_sel <= '0;
         neg_sel <= '0;
      end else if (wr_insel && !cmp_en) begin
         pos_sel <= bus_wdata[SEL_W-1:0];
         neg_sel <= bus_wdata[NEG_LO +: SEL_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_level <= '0;
         ref_src   <= 1'b0;
         ref_en    <= 1'b0;
      end else if (wr_ref) begin
         if (!ref_en) ref_level <= bus_wdata[LEVEL_W-1:0];
         ref_src <= bus_wdata[REF_SRC_BIT];
         ref_en  <= bus_wdata[REF_EN_BIT];
      end
   end

   generate
      for (genvar p = 0; p < N_EXT; p++) begin : g_pad
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        ext_pad_en[p] <= 1'b0;
            else if (wr_paden) ext_pad_en[p] <= bus_wdata[p];
         end
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         ADDR_CTRL: begin
            bus_rdata[CTRL_EN]          = cmp_en;
            bus_rdata[CTRL_IRQEN]       = irq_en;
            bus_rdata[CTRL_PADOUT]      = pad_out_en;
            bus_rdata[CTRL_MODE +: 2]   = mode;
            bus_rdata[CTRL_FLAG]        = flag;
            bus_rdata[CTRL_STAT]        = status;
         end
         ADDR_INSEL: begin
            bus_rdata[SEL_W-1:0]        = pos_sel;
            bus_rdata[NEG_LO +: SEL_W]  = neg_sel;
         end
         ADDR_REF: begin
            bus_rdata[LEVEL_W-1:0]      = ref_level;
            bus_rdata[REF_SRC_BIT]      = ref_src;
            bus_rdata[REF_EN_BIT]       = ref_en;
         end
         default: bus_rdata[N_EXT-1:0] = ext_pad_en;
      endcase
   end

   // R7: flag holds unless cleared
   a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !flag_clr) |=> flag);
   // R8: a qualifying edge wins over a same-cycle clear
   a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      edge_qual |=> flag);
   // R10: selects frozen while comparator enabled
   a_r10_sel_locked: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_en |=> ($stable(pos_sel) && $stable(neg_sel)));
   // R11: level frozen while reference enabled
   a_r11_level_locked: assert property (@(posedge clk) disable iff (!rst_n)
      ref_en |=> $stable(ref_level));

endmodule

// File: rtl/cmpirq_ctrl.sv
module cmpirq_ctrl #(
   parameter int DATA_W      = 8,
   parameter int LEVEL_W     = 5,
   parameter int SEL_W       = 3,
   parameter int N_EXT       = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic [1:0]         bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic               cmp_raw,
   output logic               cmp_en,
   output logic               ref_en,
   output logic               ref_src,
   output logic [LEVEL_W-1:0] ref_level,
   output logic [SEL_W-1:0]   pos_sel,
   output logic [SEL_W-1:0]   neg_sel,
   output logic               pad_out_en,
   output logic [N_EXT-1:0]   ext_pad_en,
   output logic               cmp_status,
   output logic               irq
);
   import cmpirq_pkg::*;

   localparam int N_SRC = N_EXT + 1;

   generate
      if (SEL_W != $clog2(N_SRC)) begin : g_bad_sel
         $error("SEL_W must encode N_EXT external sources plus the reference");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (DATA_W < 7 || DATA_W < N_EXT || DATA_W < LEVEL_W + 2 || DATA_W < 2 * SEL_W) begin : g_bad_data
         $error("DATA_W too narrow for the register fields");
      end
   endgenerate

   logic       sync_q;
   logic       edge_qual;
   logic       irq_en;
   logic       flag;
   edge_mode_e mode;

   cmpirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (!cmp_en),
      .async_in (cmp_raw),
      .sync_out (sync_q)
   );

   cmpirq_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (cmp_en),
      .sync_in (sync_q),
      .mode    (mode),
      .qual    (edge_qual)
   );

   cmpirq_regs #(
      .DATA_W  (DATA_W),
      .LEVEL_W (LEVEL_W),
      .SEL_W   (SEL_W),
      .N_EXT   (N_EXT)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .edge_qual  (edge_qual),
      .status     (sync_q),
      .cmp_en     (cmp_en),
      .irq_en     (irq_en),
      .pad_out_en (pad_out_en),
      .mode       (mode),
      .flag       (flag),
      .pos_sel    (pos_sel),
      .neg_sel    (neg_sel),
      .ref_level  (ref_level),
      .ref_src    (ref_src),
      .ref_en     (ref_en),
      .ext_pad_en (ext_pad_en)
   );

   assign cmp_status = sync_q;
   assign irq        = flag & irq_en;

   // R9: masked interrupt never reaches the pin
   a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq);
   // R2: status is low while the comparator is off
   a_r2_status_off: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_en |=> !cmp_status);

endmodule

// File: tb/cmpirq_ctrl_bench.sv
module cmpirq_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       cmp_raw = 1'b0;
   logic       cmp_en, ref_en, ref_src, pad_out_en, cmp_status, irq;
   logic [4:0] ref_level;
   logic [2:0] pos_sel, neg_sel;
   logic [6:0] ext_pad_en;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   cmpirq_ctrl u_cmpirq_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_raw(cmp_raw),
      .cmp_en(cmp_en), .ref_en(ref_en), .ref_src(ref_src), .ref_level(ref_level),
      .pos_sel(pos_sel), .neg_sel(neg_sel), .pad_out_en(pad_out_en),
      .ext_pad_en(ext_pad_en), .cmp_status(cmp_status), .irq(irq)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic read_flag(output logic f);
      logic [7:0] d;
      bus_read(2'd0, d);
      f = d[5];
   endtask

   task automatic t_reset();
      logic [7:0] d;
      for (int a = 0; a < 4; a++) begin
         bus_read(2'(a), d);
         check("R1", "register after reset", d, 8'h00);
      end
      check("R1", "drive outputs", {cmp_en, ref_en, ref_src, ref_level, pos_sel, neg_sel,
            pad_out_en, ext_pad_en, cmp_status, irq}, 32'd0);
   endtask

   task automatic t_fields();
      logic [7:0] d;
      bus_write(2'd3, 8'h55);
      check("R13", "ext_pad_en", ext_pad_en, 7'h55);
      bus_read(2'd3, d);
      check("R13", "PADEN readback", d, 8'h55);
      bus_write(2'd0, 8'h04);
      check("R13", "pad_out_en", pad_out_en, 1'b1);
      bus_write(2'd0, 8'h20);
      check("R13", "pad_out_en off", pad_out_en, 1'b0);
   endtask

   task automatic t_enable_warm();
      logic f;
      logic [7:0] d;
      cmp_raw = 1'b1;
      wait_cyc(3);
      check("R2", "status while disabled", cmp_status, 1'b0);
      bus_write(2'd0, 8'h01);
      wait_cyc(5);
      read_flag(f);
      check("R12", "no flag on enable with input high", f, 1'b0);
      check("R2", "status after enable", cmp_status, 1'b1);
      cmp_raw = 1'b0;
      wait_cyc(1);
      check("R2", "status one edge after change", cmp_status, 1'b1);
      wait_cyc(1);
      check("R2", "status two edges after change", cmp_status, 1'b0);
      bus_read(2'd0, d);
      check("R2", "status bit in CTRL", d[6], 1'b0);
      bus_write(2'd0, 8'h20);
   endtask

   task automatic t_mode(input logic [1:0] mode, input logic exp_rise,
                         input logic exp_fall, input string req);
      logic f;
      cmp_raw = 1'b0;
      bus_write(2'd0, 8'h20);
      bus_write(2'd0, {3'b000, mode, 3'b001});
      wait_cyc(4);
      read_flag(f);
      check(req, "flag before any edge", f, 1'b0);
      cmp_raw = 1'b1;
      wait_cyc(2);
      read_flag(f);
      check(req, "flag not yet after two edges", f, 1'b0);
      wait_cyc(1);
      read_flag(f);
      check(req, "flag after rising edge", f, exp_rise);
      bus_write(2'd0, {2'b01, mode, 3'b001});
      cmp_raw = 1'b0;
      wait_cyc(3);
      read_flag(f);
      check(req, "flag after falling edge", f, exp_fall);
      bus_write(2'd0, 8'h20);
   endtask

   task automatic t_sticky_irq();
      logic f;
      cmp_raw = 1'b0;
      bus_write(2'd0, 8'h01);
      wait_cyc(4);
      cmp_raw = 1'b1;
      wait_cyc(3);
      check("R9", "irq masked", irq, 1'b0);
      bus_write(2'd0, 8'h03);
      read_flag(f);
      check("R7", "flag kept after write of 0", f, 1'b1);
      check("R9", "irq with flag and enable", irq, 1'b1);
      cmp_raw = 1'b0;
      wait_cyc(2);
      bus_write(2'd0, 8'h23);
      read_flag(f);
      check("R8", "edge beats same-cycle clear", f, 1'b1);
      bus_write(2'd0, 8'h23);
      read_flag(f);
      check("R7", "flag cleared by W1C", f, 1'b0);
      check("R9", "irq drops after clear", irq, 1'b0);
      bus_write(2'd0, 8'h20);
   endtask

   task automatic t_insel_lock();
      logic [7:0] d;
      bus_write(2'd1, 8'h2B);
      check("R10", "pos_sel written when off", pos_sel, 3'd3);
      check("R10", "neg_sel written when off", neg_sel, 3'd5);
      bus_write(2'd0, 8'h01);
      bus_write(2'd1, 8'h11);
      check("R10", "pos_sel ignored when on", pos_sel, 3'd3);
      bus_read(2'd1, d);
      check("R10", "INSEL readback when on", d, 8'h2B);
      bus_write(2'd0, 8'h20);
      bus_write(2'd1, 8'h11);
      check("R10", "selects writable again", {neg_sel, pos_sel}, 6'h11);
   endtask

   task automatic t_ref_lock();
      logic [7:0] d;
      bus_write(2'd2, 8'h4A);
      check("R11", "level set with enable", ref_level, 5'h0A);
      check("R11", "ref_en set", ref_en, 1'b1);
      bus_write(2'd2, 8'h63);
      check("R11", "level ignored while enabled", ref_level, 5'h0A);
      check("R11", "src still writable", ref_src, 1'b1);
      bus_write(2'd2, 8'h03);
      bus_write(2'd2, 8'h1F);
      bus_read(2'd2, d);
      check("R11", "level writable when off", d, 8'h1F);
   endtask

   initial begin
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(1);
      t_reset();
      t_fields();
      t_enable_warm();
      t_mode(2'b00, 1'b1, 1'b1, "R3");
      t_mode(2'b01, 1'b0, 1'b1, "R4");
      t_mode(2'b10, 1'b1, 1'b0, "R5");
      t_mode(2'b11, 1'b0, 1'b0, "R6");
      t_sticky_irq();
      t_insel_lock();
      t_ref_lock();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (200000) @(posedge clk);
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule